// File: doc/BRIEF.md
# Cascaded Almost-Empty Status Bus Driver

This block sits on the read side of one device in a cascade of multi-queue devices. All devices in the cascade share a narrow status bus that carries one active-low almost-empty bit per queue. Only one device drives that bus at a time. Each device compares the device field of every strobed read address with its own fixed identity and works out whether it now owns the bus. The owner places the almost-empty flags of its local queues on the bus. Every other device keeps its bus pins released.

The same ownership decision governs the device's single discrete almost-empty output. That output reports the flag of the local queue named in the last strobe that selected this device. Tri-state pins are modelled as a data vector plus an output-enable. Both enables come from a two-state ownership machine. Its states are RELEASED and OWNER, and its transitions are CLAIM (RELEASED to OWNER on a matching strobe), YIELD (OWNER to RELEASED on a strobe for another device) and KEEP (no strobe, or a strobe that leaves the state as it is). The per-queue flags are computed elsewhere and arrive as an input vector.

Top module: `ae_status_bus_driver`

## Requirements
- R1: The read address is split so that the upper DEV_W bits are the device field and the lower log2(NQ) bits are the queue field. With the defaults (DEV_W=3, NQ=4) this is addr[4:2] for the device and addr[1:0] for the queue.
- R2: During and right after reset, a device whose DEV_ID is 0 is the owner, with both enables high. Any other device is released, with both enables low.
- R3: A strobe whose device field equals DEV_ID makes both enables high after exactly one rising clock edge. They do not change before that edge.
- R4: A strobe whose device field differs from DEV_ID makes both enables low after exactly one rising clock edge.
- R5: With the strobe low, ownership does not change, whatever the address input holds.
- R6: While the device owns the bus, bit n of the bus output equals the input flag of local queue n as sampled at the previous rising edge. A 0 means that queue is almost empty.
- R7: While the device is released, its bus enable and discrete enable are low, and its bus data and discrete data rest at all ones.
- R8: While the device owns the bus, the discrete output equals the registered flag of the queue named by the queue field of the last matching strobe. That queue is 0 after reset.
- R9: Two devices with different IDs that see the same strobes never have their bus enables high in the same cycle. On a handover, one enable rises in the same cycle that the other falls.
- R10: Without any strobe, a change of a local flag while the device owns the bus appears on the bus one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Read address strobe; samples rd_addr |
| rd_addr | input | DEV_W+log2(NQ) | Device field (upper) and queue field (lower) |
| q_ae_n | input | NQ | Active-low almost-empty flags of the local queues |
| ae_bus_o | output | NQ | Status bus data |
| ae_bus_oe | output | 1 | Status bus output enable |
| ae_disc_o | output | 1 | Discrete almost-empty data |
| ae_disc_oe | output | 1 | Discrete almost-empty output enable |

## Verification
Every one of the 32 addresses is strobed into a device with ID 5 and into a peer with ID 0. This separates a correct device-field decode from one that looks at the wrong bits, and it shows the one-edge handover between the two devices. Addresses that differ only in the queue field show that the queue bits never affect ownership. All 16 flag patterns are combined with all four queue selections while the device owns the bus. This separates the correct bus bit order and the correct discrete-output queue from swapped or stale ones. Address changes without a strobe, and flag changes without a strobe, show that ownership holds and that the bus keeps tracking the flags.

// File: rtl/ae_bus_pkg.sv
package ae_bus_pkg;

    // Ownership state of the shared almost-empty status bus
    typedef enum logic {
        ST_RELEASED = 1'b0,
        ST_OWNER    = 1'b1
    } own_state_t;

    // Transition taken on a clock edge
    typedef enum logic [1:0] {
        TR_KEEP  = 2'd0,
        TR_CLAIM = 2'd1,
        TR_YIELD = 2'd2
    } own_trans_t;

endpackage

// File: rtl/ae_addr_decode.sv
module ae_addr_decode #(
    parameter int DEV_W  = 3,
    parameter int NQ     = 4,
    parameter int DEV_ID = 0,
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int ADDR_W = DEV_W + QW
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              dev_hit_o,
    output logic [QW-1:0]     queue_o
);
    localparam logic [DEV_W-1:0] MY_ID = DEV_W'(DEV_ID);

    logic [DEV_W-1:0] dev_field;

    always_comb begin
        dev_field = addr_i[ADDR_W-1:QW];
        queue_o   = addr_i[QW-1:0];
        dev_hit_o = (dev_field == MY_ID);
    end
endmodule

// File: rtl/ae_owner_fsm.sv
module ae_owner_fsm
    import ae_bus_pkg::*;
#(
    parameter int DEV_ID = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic       dev_hit_i,
    output own_state_t state_o,
    output logic       claim_o
);
    localparam own_state_t RESET_ST = (DEV_ID == 0) ? ST_OWNER : ST_RELEASED;

    own_state_t state_q, state_d;
    own_trans_t trans;

    always_comb begin
        trans = TR_KEEP;
        if (strobe_i) begin
            unique case (state_q)
                ST_RELEASED: trans = dev_hit_i ? TR_CLAIM : TR_KEEP;
                ST_OWNER:    trans = dev_hit_i ? TR_KEEP  : TR_YIELD;
                default:     trans = TR_KEEP;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (trans)
            TR_CLAIM: state_d = ST_OWNER;
            TR_YIELD: state_d = ST_RELEASED;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o = state_q;
        claim_o = strobe_i && dev_hit_i;
    end
endmodule

// File: rtl/ae_flag_capture.sv
module ae_flag_capture #(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] flags_i,
    input  logic          sel_load_i,
    input  logic [QW-1:0] sel_i,
    output logic [NQ-1:0] flags_o,
    output logic          sel_flag_o
);
    logic [NQ-1:0] flags_q;
    logic [QW-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '1;
            sel_q   <= '0;
        end else begin
            flags_q <= flags_i;
            if (sel_load_i) sel_q <= sel_i;
        end
    end

    always_comb begin
        flags_o    = flags_q;
        sel_flag_o = 1'b1;
        for (int i = 0; i < NQ; i++) begin
            if (QW'(i) == sel_q) sel_flag_o = flags_q[i];
        end
    end
endmodule

// File: rtl/ae_status_bus_driver.sv
module ae_status_bus_driver
    import ae_bus_pkg::*;
#(
    parameter int DEV_W  = 3,
    parameter int NQ     = 4,
    parameter int DEV_ID = 0,
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int ADDR_W = DEV_W + QW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NQ-1:0]     q_ae_n,
    output logic [NQ-1:0]     ae_bus_o,
    output logic              ae_bus_oe,
    output logic              ae_disc_o,
    output logic              ae_disc_oe
);
    logic          dev_hit;
    logic [QW-1:0] queue_sel;
    own_state_t    state;
    logic          claim;
    logic [NQ-1:0] flags_reg;
    logic          sel_flag;

    ae_addr_decode #(.DEV_W(DEV_W), .NQ(NQ), .DEV_ID(DEV_ID)) dec_i (
        .addr_i    (rd_addr),
        .dev_hit_o (dev_hit),
        .queue_o   (queue_sel)
    );

    ae_owner_fsm #(.DEV_ID(DEV_ID)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (rd_strobe),
        .dev_hit_i (dev_hit),
        .state_o   (state),
        .claim_o   (claim)
    );

    ae_flag_capture #(.NQ(NQ)) flg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_i    (q_ae_n),
        .sel_load_i (claim),
        .sel_i      (queue_sel),
        .flags_o    (flags_reg),
        .sel_flag_o (sel_flag)
    );

    // Output process: enables decode the registered state only
    always_comb begin
        unique case (state)
            ST_OWNER: begin
                ae_bus_o   = flags_reg;
                ae_bus_oe  = 1'b1;
                ae_disc_o  = sel_flag;
                ae_disc_oe = 1'b1;
            end
            default: begin
                ae_bus_o   = '1;
                ae_bus_oe  = 1'b0;
                ae_disc_o  = 1'b1;
                ae_disc_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ae_status_bus_checker.sv
module ae_status_bus_checker #(
    parameter int DEV_W  = 3,
    parameter int NQ     = 4,
    parameter int DEV_ID = 0,
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int ADDR_W = DEV_W + QW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [NQ-1:0]     q_ae_n,
    input logic [NQ-1:0]     ae_bus_o,
    input logic              ae_bus_oe,
    input logic              ae_disc_o,
    input logic              ae_disc_oe
);
    logic hit;
    logic armed_q;

    assign hit = (rd_addr[ADDR_W-1:QW] == DEV_W'(DEV_ID));

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r3_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && hit) |=> (ae_bus_oe && ae_disc_oe));

    a_r4_yield: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !hit) |=> (!ae_bus_oe && !ae_disc_oe));

    a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !rd_strobe) |=> $stable(ae_bus_oe));

    a_r6_track: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ae_bus_oe) |-> (ae_bus_o == $past(q_ae_n)));

    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ae_bus_oe |-> (ae_bus_o == '1));

    a_r8_disc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ae_disc_oe |-> ae_disc_o);
endmodule

bind ae_status_bus_driver ae_status_bus_checker #(
    .DEV_W(DEV_W), .NQ(NQ), .DEV_ID(DEV_ID)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .q_ae_n(q_ae_n), .ae_bus_o(ae_bus_o), .ae_bus_oe(ae_bus_oe),
    .ae_disc_o(ae_disc_o), .ae_disc_oe(ae_disc_oe)
);

// File: tb/ae_status_bus_driver_tb.sv
module ae_status_bus_driver_tb_top;
    localparam int DEV_W = 3;
    localparam int NQ    = 4;
    localparam int AW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [NQ-1:0] q_ae_n = '1;

    logic [NQ-1:0] bus5, bus0;
    logic          oe5, oe0, disc5, doe5, disc0, doe0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ae_status_bus_driver #(.DEV_W(DEV_W), .NQ(NQ), .DEV_ID(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .q_ae_n(q_ae_n), .ae_bus_o(bus5), .ae_bus_oe(oe5),
        .ae_disc_o(disc5), .ae_disc_oe(doe5)
    );

    ae_status_bus_driver #(.DEV_W(DEV_W), .NQ(NQ), .DEV_ID(0)) peer_i (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .q_ae_n(q_ae_n), .ae_bus_o(bus0), .ae_bus_oe(oe0),
        .ae_disc_o(disc0), .ae_disc_oe(doe0)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe an address; drive at negedge, check after one rising edge
    task automatic strobe_addr(input logic [AW-1:0] a);
        logic was5, was0;
        logic exp5, exp0;
        @(negedge clk);
        was5 = oe5; was0 = oe0;
        rd_strobe = 1'b1; rd_addr = a;
        #1;
        chk("R3 no early change", int'(oe5), int'(was5));
        exp5 = (a[4:2] == 3'd5);   // R1 device field addr[4:2]
        exp0 = (a[4:2] == 3'd0);
        @(negedge clk);
        rd_strobe = 1'b0;
        chk(exp5 ? "R3 claim dev5" : "R4 yield dev5", int'(oe5), int'(exp5));
        chk("R1 R3 R4 disc enable dev5", int'(doe5), int'(exp5));
        chk(exp0 ? "R3 claim dev0" : "R4 yield dev0", int'(oe0), int'(exp0));
        chk("R9 no contention", int'(oe5 && oe0), 0);
        if (!oe5) chk("R7 idle data", int'({bus5, disc5}), 31);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 dev0 owns in reset", int'(oe0), 1);
        chk("R2 dev5 released in reset", int'(oe5), 0);
        chk("R7 released data", int'(bus5), 15);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R2 dev0 owns after reset", int'(oe0 && doe0), 1);
        chk("R2 dev5 released after reset", int'(oe5 || doe5), 0);

        // R1 R3 R4 R9: sweep all addresses, twice in different orders
        for (int a = 0; a < 32; a++) strobe_addr(AW'(a));
        for (int a = 31; a >= 0; a--) strobe_addr(AW'(a ^ 5'b10100));

        // R5: no strobe, address wanders, ownership stays
        strobe_addr(5'b10100);
        for (int a = 0; a < 32; a++) begin
            @(negedge clk) rd_addr = AW'(a);
            @(negedge clk);
            chk("R5 hold dev5", int'(oe5), 1);
            chk("R5 hold dev0", int'(oe0), 0);
        end

        // R6 R8: all flag patterns with all queue selections
        for (int q = 0; q < NQ; q++) begin
            strobe_addr(AW'({3'd5, 2'(q)}));
            for (int f = 0; f < 16; f++) begin
                @(negedge clk) q_ae_n = NQ'(f);
                @(negedge clk);
                chk("R6 bus bits", int'(bus5), f);
                chk("R8 discrete flag", int'(disc5), (f >> q) & 1);
            end
        end

        // R10: flag change without strobe shows one cycle later
        @(negedge clk) q_ae_n = 4'b1111;
        @(negedge clk) q_ae_n = 4'b0111;
        #1 chk("R10 not yet", int'(bus5), 15);
        @(negedge clk);
        chk("R10 bus follows", int'(bus5), 7);

        // R8 R7: selection persists; release restores idle discrete
        strobe_addr(5'b00001);
        chk("R7 disc released", int'(doe5), 0);
        chk("R8 dev0 disc queue1", int'(disc0), 1);
        strobe_addr(5'b10111);
        chk("R8 dev5 disc queue3", int'(disc5), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule